// File: doc/BRIEF.md
# Fracturable Lookup Logic Cell with Carry Chain

This block models one adaptive logic cell of a programmable fabric. Eight data inputs feed two halves. Each half holds a 4-input lookup table and a pair of 3-input lookup tables. Static configuration masks program the tables. Two inputs, `dataIn[1:0]`, are shared by both halves, and each half has three private inputs. Two levels of selectors merge the pieces of a half into at most one general 5-input function. Nothing joins the two halves into a wider function.

A mode input switches the cell between logic operation and arithmetic operation. In arithmetic operation, each half drives a dedicated full adder, so the cell yields two sum bits. Carry runs from the lower half to the upper half and then leaves the cell. A second chain, the shared-operand chain, runs beside the carry chain. It carries partial terms from one bit position to the next, and this lets a column of cells add three operands. Cells are chained by connecting `carryOut` and `sharedOut` to the `carryIn` and `sharedIn` of the next cell. An n-bit sum with n even needs n/2 cells plus one more cell to bring out the top carry.

Each of the two results passes through an output register stage. That stage has clear, load and enable controls, plus a per-output bypass.

Top module: `logic_cell`

## Requirements
- R1: Input mapping: shared inputs are s0=`dataIn[0]` and s1=`dataIn[1]`. Half 0 has private inputs c=`dataIn[2]`, e=`dataIn[3]`, f=`dataIn[4]`. Half 1 has c=`dataIn[5]`, e=`dataIn[6]`, f=`dataIn[7]`. In logic mode (`cellMode` code 0, and also the unused code 3), result h is defined as follows. When s1=1, it is bit {f,e,c,s0} of `cfgLut4[h]`. When s1=0, it is bit {e,c,s0} of `cfgLut3B[h]` if f=1, otherwise the same bit of `cfgLut3A[h]`.
- R2: Result 0 depends only on `dataIn[4:0]` and the half-0 masks. Changing `dataIn[7:5]` or any half-1 mask leaves it unchanged.
- R3: In two-operand add mode (code 1), each half adds two operands and a carry. Operand A is its 4-input table value. Operand B is its selected 3-input table value (chosen by f). The carry comes from below. The sum bit is the result, and the majority carry ripples from half 0 to half 1 and then to `carryOut`.
- R4: In three-operand add mode (code 2), operand B of half 0 is `sharedIn` and operand B of half 1 is the selected 3-input value of half 0. The selected 3-input value of half 1 drives `sharedOut`.
- R5: `carryOut` and `sharedOut` are 0 in logic mode, and `sharedOut` is 0 in two-operand add mode.
- R6: A synchronous clear of a register forces it to 0 and overrides load and enable.
- R7: A synchronous load copies the matching `loadData` bit into the register and overrides enable.
- R8: With enable set, a register captures its result at the clock edge. With no control set, it holds its value.
- R9: A `regBypass` bit of 1 drives the matching `cellOut` bit from the unregistered result. A bit of 0 drives it from the register.
- R10: `rstN` low clears both registers at once, with no clock edge needed.
- R11: Three chained cells in two-operand mode form a 4-bit adder with carry-in. The third cell has all-zero masks and presents the carry-out on its result 0.
- R12: Three chained cells in three-operand mode, with the tables set to the per-bit XOR and majority, give the 6-bit sum of three 4-bit operands plus carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rstN | input | 1 | Active-low asynchronous reset |
| cellMode | input | 2 | 0 logic, 1 two-operand add, 2 three-operand add, 3 logic |
| cfgLut4 | input | 2x16 | 4-input table mask per half |
| cfgLut3A | input | 2x8 | 3-input table mask selected when f=0, per half |
| cfgLut3B | input | 2x8 | 3-input table mask selected when f=1, per half |
| dataIn | input | 8 | Data inputs |
| carryIn | input | 1 | Carry from the previous cell |
| sharedIn | input | 1 | Shared-operand chain from the previous cell |
| regEn | input | 2 | Per-register capture enable |
| regClr | input | 2 | Per-register synchronous clear |
| regLoad | input | 2 | Per-register synchronous load |
| loadData | input | 2 | Values for synchronous load |
| regBypass | input | 2 | Per-output select of the unregistered result |
| cellOut | output | 2 | Cell results |
| carryOut | output | 1 | Carry to the next cell |
| sharedOut | output | 1 | Shared-operand chain to the next cell |

## Verification
Several properties are checked on every clock cycle:
- The register controls decode so that at most one action is applied to each register.
- Clear, load and hold take effect one cycle after they are requested.
- The two chains stay silent in logic mode.
- In either add mode, the two sum bits and the carry-out always equal the arithmetic total of the operands and carry-in.

Other behaviour can only be shown by the bench's scenarios:
- that each table bit maps to the right input combination;
- that the halves do not interact;
- that a three-cell column yields correct 4-bit two-operand sums and three-operand sums;
- that the register priorities produce the right values at the ports.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int NUM_HALF   = 2;
  localparam int NUM_OUT    = NUM_HALF;
  localparam int SMALL_IN   = 3;
  localparam int BIG_IN     = SMALL_IN + 1;
  localparam int SMALL_BITS = 1 << SMALL_IN;
  localparam int BIG_BITS   = 1 << BIG_IN;
  localparam int SHARED_IN  = 2;
  localparam int PRIV_IN    = 3;
  localparam int DATA_W     = SHARED_IN + NUM_HALF * PRIV_IN;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_ADD2  = 2'd1,
    MODE_ADD3  = 2'd2,
    MODE_RSVD  = 2'd3
  } cellMode_e;

  typedef struct packed {
    logic [NUM_OUT-1:0] clr;
    logic [NUM_OUT-1:0] load;
    logic [NUM_OUT-1:0] cap;
  } regStrobe_t;
endpackage

// File: rtl/cell_half.sv
module cell_half
  import lcell_pkg::*;
(
  input  logic                  sharedLo,
  input  logic                  sharedHi,
  input  logic [PRIV_IN-1:0]    priv,
  input  logic [BIG_BITS-1:0]   lut4Mask,
  input  logic [SMALL_BITS-1:0] lut3AMask,
  input  logic [SMALL_BITS-1:0] lut3BMask,
  input  cellMode_e             mode,
  input  logic                  carryIn,
  input  logic                  sharedIn,
  output logic                  result,
  output logic                  carryOut,
  output logic                  sharedOut,
  output logic                  opAOut,
  output logic                  opBOut
);
  logic                pinC, pinE, pinF;
  logic [SMALL_IN-1:0] idxSmall;
  logic [BIG_IN-1:0]   idxBig;
  logic                lutBig, lutSmallA, lutSmallB, pairSel, logicVal;
  logic                isArith, sumBit, majBit;

  assign pinC = priv[0];
  assign pinE = priv[1];
  assign pinF = priv[2];

  assign idxSmall  = {pinE, pinC, sharedLo};
  assign idxBig    = {pinF, pinE, pinC, sharedLo};
  assign lutBig    = lut4Mask[idxBig];
  assign lutSmallA = lut3AMask[idxSmall];
  assign lutSmallB = lut3BMask[idxSmall];

  // first fracture selector: the pair of small tables acts as one 4-input table
  assign pairSel  = pinF ? lutSmallB : lutSmallA;
  // second fracture selector: merge with the big table into one 5-input function
  assign logicVal = sharedHi ? lutBig : pairSel;

  assign isArith = (mode == MODE_ADD2) || (mode == MODE_ADD3);
  assign opAOut  = lutBig;
  assign opBOut  = (mode == MODE_ADD3) ? sharedIn : pairSel;

  assign sumBit = opAOut ^ opBOut ^ carryIn;
  assign majBit = (opAOut & opBOut) | (opAOut & carryIn) | (opBOut & carryIn);

  assign result    = isArith ? sumBit : logicVal;
  assign carryOut  = isArith & majBit;
  assign sharedOut = (mode == MODE_ADD3) & pairSel;
endmodule

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import lcell_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] regEn,
  input  logic [NUM_OUT-1:0] regClr,
  input  logic [NUM_OUT-1:0] regLoad,
  output regStrobe_t         strb
);
  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      strb.clr[i]  = regClr[i];
      strb.load[i] = !regClr[i] && regLoad[i];
      strb.cap[i]  = !regClr[i] && !regLoad[i] && regEn[i];
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strb.clr[g], strb.load[g], strb.cap[g]}));
  end
endmodule

// File: rtl/cell_datapath.sv
module cell_datapath
  import lcell_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  cellMode_e                             modeSel,
  input  logic [NUM_HALF-1:0][BIG_BITS-1:0]     cfgLut4,
  input  logic [NUM_HALF-1:0][SMALL_BITS-1:0]   cfgLut3A,
  input  logic [NUM_HALF-1:0][SMALL_BITS-1:0]   cfgLut3B,
  input  logic [DATA_W-1:0]                     dataIn,
  input  logic                                  carryIn,
  input  logic                                  sharedIn,
  input  regStrobe_t                            strb,
  input  logic [NUM_OUT-1:0]                    loadData,
  input  logic [NUM_OUT-1:0]                    regBypass,
  output logic [NUM_OUT-1:0]                    cellOut,
  output logic                                  carryOut,
  output logic                                  sharedOut
);
  logic [NUM_HALF:0]    carryChain, shareChain;
  logic [NUM_HALF-1:0]  halfRes, opA, opB;
  logic [NUM_OUT-1:0]   regQ;

  assign carryChain[0] = carryIn;
  assign shareChain[0] = sharedIn;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    cell_half i_half (
      .sharedLo  (dataIn[0]),
      .sharedHi  (dataIn[1]),
      .priv      (dataIn[SHARED_IN + h*PRIV_IN +: PRIV_IN]),
      .lut4Mask  (cfgLut4[h]),
      .lut3AMask (cfgLut3A[h]),
      .lut3BMask (cfgLut3B[h]),
      .mode      (modeSel),
      .carryIn   (carryChain[h]),
      .sharedIn  (shareChain[h]),
      .result    (halfRes[h]),
      .carryOut  (carryChain[h+1]),
      .sharedOut (shareChain[h+1]),
      .opAOut    (opA[h]),
      .opBOut    (opB[h])
    );
  end

  assign carryOut  = carryChain[NUM_HALF];
  assign sharedOut = shareChain[NUM_HALF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (strb.clr[i])       regQ[i] <= 1'b0;
        else if (strb.load[i]) regQ[i] <= loadData[i];
        else if (strb.cap[i])  regQ[i] <= halfRes[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++)
      cellOut[i] = regBypass[i] ? halfRes[i] : regQ[i];
  end

  // R3 R4: two sum bits and carry-out equal the arithmetic total
  add_total_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_ADD2 || modeSel == MODE_ADD3) |->
      ({carryOut, halfRes[1], halfRes[0]} ==
       (3'(opA[0]) + 3'(opB[0]) + 3'(carryIn) + 3'({opA[1], 1'b0}) + 3'({opB[1], 1'b0}))));

  // R5
  logic_chain_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_LOGIC || modeSel == MODE_RSVD) |-> (!carryOut && !sharedOut));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_regchk
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.clr[g] |=> (regQ[g] == 1'b0));
    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.load[g] |=> (regQ[g] == $past(loadData[g])));
    // R8
    hold_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.clr[g] || strb.load[g] || strb.cap[g]) |=> $stable(regQ[g]));
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [1:0]                          cellMode,
  input  logic [NUM_HALF-1:0][BIG_BITS-1:0]   cfgLut4,
  input  logic [NUM_HALF-1:0][SMALL_BITS-1:0] cfgLut3A,
  input  logic [NUM_HALF-1:0][SMALL_BITS-1:0] cfgLut3B,
  input  logic [DATA_W-1:0]                   dataIn,
  input  logic                                carryIn,
  input  logic                                sharedIn,
  input  logic [NUM_OUT-1:0]                  regEn,
  input  logic [NUM_OUT-1:0]                  regClr,
  input  logic [NUM_OUT-1:0]                  regLoad,
  input  logic [NUM_OUT-1:0]                  loadData,
  input  logic [NUM_OUT-1:0]                  regBypass,
  output logic [NUM_OUT-1:0]                  cellOut,
  output logic                                carryOut,
  output logic                                sharedOut
);
  regStrobe_t strb;
  cellMode_e  modeSel;

  assign modeSel = cellMode_e'(cellMode);

  cell_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regEn   (regEn),
    .regClr  (regClr),
    .regLoad (regLoad),
    .strb    (strb)
  );

  cell_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .cfgLut4   (cfgLut4),
    .cfgLut3A  (cfgLut3A),
    .cfgLut3B  (cfgLut3B),
    .dataIn    (dataIn),
    .carryIn   (carryIn),
    .sharedIn  (sharedIn),
    .strb      (strb),
    .loadData  (loadData),
    .regBypass (regBypass),
    .cellOut   (cellOut),
    .carryOut  (carryOut),
    .sharedOut (sharedOut)
  );
endmodule

// File: tb/test_logic_cell.sv
module test_logic_cell;
  localparam int NE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]       mode [NE];
  logic [1:0][15:0] l4   [NE];
  logic [1:0][7:0]  l3a  [NE];
  logic [1:0][7:0]  l3b  [NE];
  logic [7:0]       din  [NE];
  logic [1:0]       outv [NE];
  logic [NE:0]      cch, sch;
  logic cin, shIn;
  logic [1:0] regEn, regClr, regLoad, loadData, regBypass;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  assign cch[0] = cin;
  assign sch[0] = shIn;

  for (genvar k = 0; k < NE; k++) begin : g_elem
    logic_cell i_logic_cell (
      .clk(clk), .rstN(rstN), .cellMode(mode[k]),
      .cfgLut4(l4[k]), .cfgLut3A(l3a[k]), .cfgLut3B(l3b[k]),
      .dataIn(din[k]), .carryIn(cch[k]), .sharedIn(sch[k]),
      .regEn(regEn), .regClr(regClr), .regLoad(regLoad),
      .loadData(loadData), .regBypass(regBypass),
      .cellOut(outv[k]), .carryOut(cch[k+1]), .sharedOut(sch[k+1])
    );
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // logic-mode value of one half as stated in R1
  function automatic logic refLogic(input logic [15:0] m4, input logic [7:0] ma,
                                    input logic [7:0] mb, input logic s0, input logic s1,
                                    input logic c, input logic e, input logic f);
    logic [3:0] i4;
    logic [2:0] i3;
    i4 = {f, e, c, s0};
    i3 = {e, c, s0};
    if (s1) return m4[i4];
    return f ? mb[i3] : ma[i3];
  endfunction

  function automatic logic [15:0] xorMask();
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = i[1] ^ i[2] ^ i[3];
    return m;
  endfunction

  task automatic setAll(input logic [1:0] md, input logic [15:0] m4, input logic [7:0] ma,
                        input logic [7:0] mb);
    for (int k = 0; k < NE; k++) begin
      mode[k] = md;
      l4[k]  = {m4, m4};
      l3a[k] = {ma, ma};
      l3b[k] = {mb, mb};
      din[k] = 8'h00;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd;
    logic [7:0]  exp8;
    rnd = $urandom(32'h5eed);
    cin = 1'b0; shIn = 1'b0;
    regEn = '0; regClr = '0; regLoad = '0; loadData = '0; regBypass = '0;
    setAll(2'd0, 16'hFFFF, 8'hFF, 8'hFF);

    // R10: reset holds registers at zero
    repeat (3) @(posedge clk);
    @(negedge clk);
    regEn = 2'b11;
    #5 chk("R10 reset", {6'd0, outv[0]}, 8'h00);
    rstN = 1'b1;
    regEn = 2'b00;

    // R1 R5: random logic-mode configurations, bypassed
    regBypass = 2'b11;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      mode[0] = (n % 4 == 3) ? 2'd3 : 2'd0;
      l4[0]  = {$urandom(), $urandom()};
      l3a[0] = {$urandom(), $urandom()};
      l3b[0] = {$urandom(), $urandom()};
      din[0] = 8'($urandom());
      cin    = 1'($urandom());
      shIn   = 1'($urandom());
      #5;
      chk("R1 half0", {7'd0, outv[0][0]},
          {7'd0, refLogic(l4[0][0], l3a[0][0], l3b[0][0], din[0][0], din[0][1],
                          din[0][2], din[0][3], din[0][4])});
      chk("R1 half1", {7'd0, outv[0][1]},
          {7'd0, refLogic(l4[0][1], l3a[0][1], l3b[0][1], din[0][0], din[0][1],
                          din[0][5], din[0][6], din[0][7])});
      chk("R5 chains quiet", {6'd0, cch[1], sch[1]}, 8'h00);
    end

    // R2: half-1 stimulus never moves result 0
    @(negedge clk);
    mode[0] = 2'd0; cin = 1'b0; shIn = 1'b0;
    l4[0][0] = 16'h6A5C; l3a[0][0] = 8'h3B; l3b[0][0] = 8'hD2;
    din[0][4:0] = 5'b10110;
    #5 exp8 = {7'd0, outv[0][0]};
    chk("R2 baseline", exp8,
        {7'd0, refLogic(16'h6A5C, 8'h3B, 8'hD2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1)});
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      din[0][7:5] = 3'(n);
      l4[0][1] = 16'($urandom()); l3a[0][1] = 8'($urandom()); l3b[0][1] = 8'($urandom());
      #5 chk("R2 half isolation", {7'd0, outv[0][0]}, exp8);
    end

    // R3 R5 R11: exhaustive 4-bit two-operand add, third cell recovers carry
    @(negedge clk);
    setAll(2'd1, 16'hCCCC, 8'hF0, 8'hF0);
    mode[2] = 2'd1; l4[2] = '0; l3a[2] = '0; l3b[2] = '0;
    shIn = 1'b0;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          cin = 1'(c);
          din[0] = {1'b0, 1'(b >> 1), 1'(a >> 1), 1'b0, 1'(b), 1'(a), 2'b00};
          din[1] = {1'b0, 1'(b >> 3), 1'(a >> 3), 1'b0, 1'(b >> 2), 1'(a >> 2), 2'b00};
          din[2] = 8'h00;
          #5;
          chk("R11 R3 add2", {3'd0, outv[2][0], outv[1], outv[0]}, 8'(a + b + c));
          if (a == 15 && b == 15) chk("R5 no shared in add2", {7'd0, sch[NE]}, 8'h00);
        end
      end
    end

    // R4 R12: three-operand add through the shared chain
    @(negedge clk);
    setAll(2'd2, xorMask(), 8'hC0, 8'hFC);
    l4[2] = '0; l3a[2] = '0; l3b[2] = '0;
    for (int n = 0; n < 300; n++) begin
      logic [3:0] x, y, z;
      logic c;
      @(negedge clk);
      if (n == 0) begin x = 4'hF; y = 4'hF; z = 4'hF; c = 1'b1; end
      else if (n == 1) begin x = 4'h0; y = 4'h0; z = 4'h0; c = 1'b0; end
      else if (n == 2) begin x = 4'h8; y = 4'h8; z = 4'h8; c = 1'b0; end
      else begin
        rnd = $urandom();
        x = rnd[3:0]; y = rnd[7:4]; z = rnd[11:8]; c = rnd[12];
      end
      cin = c;
      din[0] = {z[1], y[1], x[1], z[0], y[0], x[0], 2'b00};
      din[1] = {z[3], y[3], x[3], z[2], y[2], x[2], 2'b00};
      din[2] = 8'h00;
      #5;
      chk("R12 R4 add3", {2'd0, outv[2], outv[1], outv[0]},
          8'(x) + 8'(y) + 8'(z) + 8'(c));
    end

    // R6 R7 R8 R9: register controls on cell 0
    @(negedge clk);
    setAll(2'd0, 16'hFFFF, 8'hFF, 8'hFF);
    cin = 1'b0;
    regBypass = 2'b00;
    regEn = 2'b11;
    @(posedge clk); #5 chk("R8 capture", {6'd0, outv[0]}, 8'h03);
    @(negedge clk);
    regEn = 2'b00;
    setAll(2'd0, 16'h0000, 8'h00, 8'h00);
    @(posedge clk); #5 chk("R8 hold", {6'd0, outv[0]}, 8'h03);
    @(negedge clk);
    regLoad = 2'b11; loadData = 2'b01;
    @(posedge clk); #5 chk("R7 load", {6'd0, outv[0]}, 8'h01);
    @(negedge clk);
    regLoad = 2'b11; loadData = 2'b10; regEn = 2'b11;
    @(posedge clk); #5 chk("R7 load over enable", {6'd0, outv[0]}, 8'h02);
    @(negedge clk);
    loadData = 2'b11; regClr = 2'b11;
    @(posedge clk); #5 chk("R6 clear wins", {6'd0, outv[0]}, 8'h00);
    @(negedge clk);
    regClr = 2'b00; regLoad = 2'b00; regEn = 2'b01;
    setAll(2'd0, 16'hFFFF, 8'hFF, 8'hFF);
    @(posedge clk); #5 chk("R8 per-register enable", {6'd0, outv[0]}, 8'h01);
    @(negedge clk);
    regEn = 2'b00;
    regBypass = 2'b10;
    #5 chk("R9 bypass upper", {6'd0, outv[0]}, 8'h03);
    setAll(2'd0, 16'h0000, 8'h00, 8'h00);
    #2 chk("R9 bypass follows result", {6'd0, outv[0]}, 8'h01);
    regBypass = 2'b00;
    #1 chk("R9 registered view", {6'd0, outv[0]}, 8'h01);
    rstN = 1'b0;
    #1 chk("R10 async reset", {6'd0, outv[0]}, 8'h00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule